// File: doc/BRIEF.md
# Calibration Sequence Controller

This block orders the digital steps of a converter self-calibration. A calibration is made of up to three phases: a DAC-segment trim, an offset trim and a gain trim. Each phase is modelled as a counted interval whose length is a parameter, and a one-cycle completion pulse follows it. The analog trimming is outside this block.

A calibration can start in two ways. A falling edge on the active-low hardware request pin always runs all three phases. A strobed 4-bit software code can select a partial calibration or a coefficient-memory transfer. In device mode, the phases run back to back under a single low period of the active-low busy output. In system mode, busy goes low once for each phase. Before each offset or gain phase the controller idles with busy high until the host gives a rising edge on the start-conversion input, so that the host can first apply the external reference voltage.

Every start terminates any conversion in progress and restarts the controller from its first phase. Software can pause a running calibration and resume it later through a halt flag.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, busy_n is 1 and cal_active, halted, conv_abort, phase_done and coef_req are 0.
- R2: A falling edge on cal_n starts all three phases, whatever the software code. mode_sel is sampled at that edge: 0 selects device mode and 1 selects system mode.
- R3: Every calibration start, from hardware or from software, raises conv_abort for exactly one cycle (the cycle after the start is sampled). A start during a running calibration discards that calibration and begins again from the first phase of the new request.
- R4: In device mode, busy_n is low for one unbroken stretch. Its length is the sum of the lengths of the selected phases. cal_active is high for the whole calibration and falls in the same cycle that busy_n rises.
- R5: In system mode, busy_n has one low pulse per selected phase, in the order DAC, offset, gain. Each pulse is exactly as long as its phase parameter. Before any offset or gain phase, busy_n stays high and cal_active stays high until a rising edge on conv_start.
- R6: The software code (sw_code, taken when sw_go is high) is decoded as follows. Bit 0 selects the mode: 1 for system, 0 for device. Bits 3..1 select the phases: 001 for gain only, 010 for offset only, 011 for offset and gain, and 111 for DAC, offset and gain.
- R7: Codes 0000 and 0001 start nothing and have no effect on a calibration that is already running.
- R8: Codes 1000 through 1101 start no timed phase. When the controller is idle, such a code raises coef_req for one cycle and places the code on coef_op. While a calibration is running, the code is ignored.
- R9: A halt write with value 1 during a calibration sets halted. While halted is set, the remaining phase time is frozen and conv_start edges are ignored. A halt write with value 0 clears halted, and the calibration resumes with the time it had left. A halt write with value 1 while idle leaves halted at 0.
- R10: phase_done is a one-cycle pulse in the cycle after the last busy-low cycle of each phase, so that a calibration gives one pulse per selected phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_n | input | 1 | Hardware calibration request; its falling edge starts a full calibration |
| mode_sel | input | 1 | Mode for a hardware request: 0 device, 1 system |
| sw_go | input | 1 | One-cycle strobe that takes sw_code |
| sw_code | input | 4 | Software calibration or coefficient-transfer code |
| conv_start | input | 1 | Start-conversion input; its rising edge releases a system-mode wait |
| halt_wr | input | 1 | Write strobe for the halt flag |
| halt_val | input | 1 | Value written to the halt flag |
| busy_n | output | 1 | Low while a phase interval is running |
| cal_active | output | 1 | High for the whole calibration, including waits |
| halted | output | 1 | Calibration paused |
| conv_abort | output | 1 | One-cycle pulse that terminates any conversion in progress |
| phase_done | output | 1 | One-cycle pulse after each completed phase |
| coef_req | output | 1 | One-cycle request to open the coefficient memory |
| coef_op | output | 4 | Code of the last accepted coefficient transfer |

## Verification
The bench builds the controller with phase lengths of 5 (DAC), 3 (offset) and 4 (gain) cycles. Because these lengths are short and all different, every one of the sixteen software codes can be run in full, and both hardware modes can be run as well. The order of the system-mode pulses can then be read directly from the pulse widths. The short lengths also make the arithmetic easy to predict: the merged busy stretch after an override, the extension caused by a halt, and the ignored requests in the middle of a run.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    // Phase index doubles as the bit position in a phase mask.
    typedef enum logic [1:0] {
        PH_DAC  = 2'd0,
        PH_OFS  = 2'd1,
        PH_GAIN = 2'd2
    } phase_t;

    localparam int NUM_PHASES = 3;

    function automatic phase_t first_phase(input logic [NUM_PHASES-1:0] mask);
        phase_t p;
        p = PH_GAIN;
        for (int i = NUM_PHASES - 1; i >= 0; i--) begin
            if (mask[i]) p = phase_t'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/cal_seq_edge.sv
module cal_seq_edge #(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;
endmodule

// File: rtl/cal_seq_decode.sv
module cal_seq_decode
    import cal_seq_pkg::*;
(
    input  logic [3:0]            code,
    output logic [NUM_PHASES-1:0] mask,
    output logic                  sys,
    output logic                  coef
);
    always_comb begin
        mask = '0;
        coef = 1'b0;
        sys  = code[0];
        unique case (code[3:1])
            3'b001:  mask = 3'b100;
            3'b010:  mask = 3'b010;
            3'b011:  mask = 3'b110;
            3'b111:  mask = 3'b111;
            3'b100,
            3'b101,
            3'b110:  coef = 1'b1;
            default: mask = '0;
        endcase
    end
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int unsigned DAC_LEN  = 6359324,
    parameter int unsigned OFS_LEN  = 1475104,
    parameter int unsigned GAIN_LEN = 1442324
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cal_n,
    input  logic       mode_sel,
    input  logic       sw_go,
    input  logic [3:0] sw_code,
    input  logic       conv_start,
    input  logic       halt_wr,
    input  logic       halt_val,
    output logic       busy_n,
    output logic       cal_active,
    output logic       halted,
    output logic       conv_abort,
    output logic       phase_done,
    output logic       coef_req,
    output logic [3:0] coef_op
);
    localparam int unsigned MAX_A   = (DAC_LEN > OFS_LEN) ? DAC_LEN : OFS_LEN;
    localparam int unsigned MAX_LEN = (MAX_A > GAIN_LEN) ? MAX_A : GAIN_LEN;
    localparam int          CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        seq_state_t            state;
        phase_t                phase;
        logic [NUM_PHASES-1:0] rest;
        logic                  sys;
        logic [CNT_W-1:0]      cnt;
        logic                  halted;
        logic                  abort;
        logic                  done;
        logic                  coef_req;
        logic [3:0]            coef_op;
    } regs_t;

    regs_t q, d;

    logic                  hw_fall, hw_rise_unused;
    logic                  cs_rise, cs_fall_unused;
    logic [NUM_PHASES-1:0] dec_mask;
    logic                  dec_sys, dec_coef;

    cal_seq_edge #(.IDLE_LVL(1'b1)) u_hw_edge (
        .clk(clk), .rst_n(rst_n), .din(cal_n),
        .rise(hw_rise_unused), .fall(hw_fall)
    );

    cal_seq_edge #(.IDLE_LVL(1'b0)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(conv_start),
        .rise(cs_rise), .fall(cs_fall_unused)
    );

    cal_seq_decode u_dec (
        .code(sw_code), .mask(dec_mask), .sys(dec_sys), .coef(dec_coef)
    );

    function automatic logic [CNT_W-1:0] load_of(input phase_t p);
        unique case (p)
            PH_DAC:  return CNT_W'(DAC_LEN - 1);
            PH_OFS:  return CNT_W'(OFS_LEN - 1);
            default: return CNT_W'(GAIN_LEN - 1);
        endcase
    endfunction

    logic                  start;
    logic [NUM_PHASES-1:0] start_mask;
    logic                  start_sys;
    phase_t                ph_first;
    phase_t                ph_next;

    always_comb begin
        d          = q;
        d.abort    = 1'b0;
        d.done     = 1'b0;
        d.coef_req = 1'b0;

        start      = 1'b0;
        start_mask = '0;
        start_sys  = 1'b0;
        if (hw_fall) begin
            start      = 1'b1;
            start_mask = '1;
            start_sys  = mode_sel;
        end else if (sw_go && (dec_mask != '0)) begin
            start      = 1'b1;
            start_mask = dec_mask;
            start_sys  = dec_sys;
        end else if (sw_go && dec_coef && (q.state == ST_IDLE)) begin
            d.coef_req = 1'b1;
            d.coef_op  = sw_code;
        end

        if (halt_wr) begin
            if (!halt_val)                 d.halted = 1'b0;
            else if (q.state != ST_IDLE)   d.halted = 1'b1;
        end

        ph_first = first_phase(start_mask);
        ph_next  = first_phase(q.rest);

        if (start) begin
            d.abort  = 1'b1;
            d.halted = 1'b0;
            d.sys    = start_sys;
            d.phase  = ph_first;
            d.rest   = start_mask & ~(NUM_PHASES'(1) << ph_first);
            d.cnt    = load_of(ph_first);
            d.state  = (start_sys && ph_first != PH_DAC) ? ST_WAIT : ST_RUN;
        end else begin
            unique case (q.state)
                ST_RUN: begin
                    if (!q.halted) begin
                        if (q.cnt == '0) begin
                            d.done = 1'b1;
                            if (q.rest == '0) begin
                                d.state  = ST_IDLE;
                                d.halted = 1'b0;
                            end else begin
                                d.phase = ph_next;
                                d.rest  = q.rest & ~(NUM_PHASES'(1) << ph_next);
                                d.cnt   = load_of(ph_next);
                                d.state = q.sys ? ST_WAIT : ST_RUN;
                            end
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!q.halted && cs_rise) d.state = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_DAC, rest: '0, sys: 1'b0,
                   cnt: '0, halted: 1'b0, abort: 1'b0, done: 1'b0,
                   coef_req: 1'b0, coef_op: 4'h0};
        end else begin
            q <= d;
        end
    end

    assign busy_n     = (q.state != ST_RUN);
    assign cal_active = (q.state != ST_IDLE);
    assign halted     = q.halted;
    assign conv_abort = q.abort;
    assign phase_done = q.done;
    assign coef_req   = q.coef_req;
    assign coef_op    = q.coef_op;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_n,
    input logic sw_go,
    input logic busy_n,
    input logic cal_active,
    input logic halted,
    input logic conv_abort,
    input logic phase_done,
    input logic coef_req
);
    p_busy_in_cal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> cal_active);

    p_halt_in_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> cal_active);

    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && cal_n && !sw_go) |=> (cal_active && $stable(busy_n)));

    p_abort_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> cal_active);

    p_hw_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_n) |=> conv_abort);

    p_coef_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        coef_req |-> !cal_active);

    p_done_after_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> $past(!busy_n));
endmodule

bind cal_seq_ctrl cal_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cal_n(cal_n), .sw_go(sw_go),
    .busy_n(busy_n), .cal_active(cal_active), .halted(halted),
    .conv_abort(conv_abort), .phase_done(phase_done), .coef_req(coef_req)
);

// File: tb/tb_cal_seq_ctrl.sv
module tb_cal_seq_ctrl;
    localparam int L_DAC = 5, L_OFS = 3, L_GAIN = 4;

    logic       clk = 0, rst_n = 0;
    logic       cal_n = 1, mode_sel = 0, sw_go = 0, conv_start = 0;
    logic       halt_wr = 0, halt_val = 0;
    logic [3:0] sw_code = 0;
    logic       busy_n, cal_active, halted, conv_abort, phase_done, coef_req;
    logic [3:0] coef_op;

    int n_chk = 0, n_fail = 0;
    int lens[8];
    int np = 0, cur = 0, nd = 0;

    always #5 clk = ~clk;

    cal_seq_ctrl #(.DAC_LEN(L_DAC), .OFS_LEN(L_OFS), .GAIN_LEN(L_GAIN)) dut (
        .clk(clk), .rst_n(rst_n), .cal_n(cal_n), .mode_sel(mode_sel),
        .sw_go(sw_go), .sw_code(sw_code), .conv_start(conv_start),
        .halt_wr(halt_wr), .halt_val(halt_val), .busy_n(busy_n),
        .cal_active(cal_active), .halted(halted), .conv_abort(conv_abort),
        .phase_done(phase_done), .coef_req(coef_req), .coef_op(coef_op)
    );

    // Pulse monitor: measures busy-low widths and counts done pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy_n) cur <= cur + 1;
            else if (cur != 0) begin
                if (np < 8) lens[np] <= cur;
                np  <= np + 1;
                cur <= 0;
            end
            if (phase_done) nd <= nd + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk);
        np = 0; cur = 0; nd = 0;
    endtask

    function automatic logic [2:0] exp_mask(input logic [3:0] c);
        case (c[3:1])
            3'b001:  return 3'b100;
            3'b010:  return 3'b010;
            3'b011:  return 3'b110;
            3'b111:  return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic int plen(input int p);
        return (p == 0) ? L_DAC : (p == 1) ? L_OFS : L_GAIN;
    endfunction

    // Run until idle; in strobe mode, pulse conv_start after 3 idle-wait cycles.
    task automatic wait_idle(input bit strobe, input string req);
        int w = 0;
        bit ended = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            conv_start = 0;
            if (!cal_active) begin ended = 1; break; end
            if (strobe && busy_n) begin
                w++;
                if (w == 3) begin conv_start = 1; w = 0; end
            end
        end
        conv_start = 0;
        chk(ended, req, 0, 1);
        @(negedge clk);
    endtask

    task automatic check_pulses(input bit sys, input logic [2:0] m, input string req);
        int k = 0;
        int sum = 0;
        int cnt = $countones(m);
        if (sys) begin
            chk(np == cnt, req, np, cnt);
            for (int p = 0; p < 3; p++) begin
                if (m[p]) begin
                    if (k < np) chk(lens[k] == plen(p), req, lens[k], plen(p));
                    k++;
                end
            end
        end else begin
            for (int p = 0; p < 3; p++) if (m[p]) sum += plen(p);
            chk(np == 1, req, np, 1);
            chk(lens[0] == sum, req, lens[0], sum);
        end
        chk(nd == cnt, "R10", nd, cnt);
    endtask

    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_n == 1 && cal_active == 0 && halted == 0, "R1", busy_n, 1);
        chk(conv_abort == 0 && phase_done == 0 && coef_req == 0, "R1", coef_req, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R6 R7 R8 sweep of every software code
        for (int c = 0; c < 16; c++) begin
            logic [2:0] m;
            bit co;
            m  = exp_mask(4'(c));
            co = (c >= 8 && c <= 13);
            clr_mon();
            sw_code = 4'(c); sw_go = 1;
            @(negedge clk);
            sw_go = 0;
            chk(conv_abort == (m != 0), "R3", conv_abort, m != 0);
            chk(coef_req == co, "R8", coef_req, co);
            if (co) chk(coef_op == 4'(c), "R8", coef_op, c);
            if (m != 0) begin
                wait_idle(c[0], "R6");
                check_pulses(c[0], m, c[0] ? "R5" : "R4");
            end else begin
                chk(cal_active == 0, "R7", cal_active, 0);
                repeat (3) @(negedge clk);
                chk(np == 0, "R7", np, 0);
            end
        end

        // R2 hardware request in both modes, software code held at 0000
        for (int md = 0; md < 2; md++) begin
            clr_mon();
            sw_code = 4'h0; mode_sel = md[0]; cal_n = 0;
            @(negedge clk);
            chk(conv_abort == 1, "R2", conv_abort, 1);
            mode_sel = ~md[0];
            cal_n = 1;
            wait_idle(md[0], "R2");
            check_pulses(md[0], 3'b111, "R2");
        end

        // R3 override: system full run, hardware device request after 2 low cycles
        clr_mon();
        sw_code = 4'hF; sw_go = 1;
        @(negedge clk); sw_go = 0;
        @(negedge clk);
        mode_sel = 0; cal_n = 0;
        @(negedge clk);
        chk(conv_abort == 1, "R3", conv_abort, 1);
        cal_n = 1;
        wait_idle(0, "R3");
        chk(np == 1, "R3", np, 1);
        chk(lens[0] == 2 + L_DAC + L_OFS + L_GAIN, "R3", lens[0], 2 + L_DAC + L_OFS + L_GAIN);

        // R7 R8 ignored requests during a run (device offset+gain)
        clr_mon();
        sw_code = 4'h6; sw_go = 1;
        @(negedge clk); sw_code = 4'h0;
        @(negedge clk); sw_go = 0;
        chk(conv_abort == 0, "R7", conv_abort, 0);
        sw_code = 4'h8; sw_go = 1;
        @(negedge clk); sw_go = 0;
        chk(coef_req == 0, "R8", coef_req, 0);
        wait_idle(0, "R7");
        chk(np == 1 && lens[0] == L_OFS + L_GAIN, "R7", lens[0], L_OFS + L_GAIN);

        // R9 halt extends the low stretch by the halted cycles
        clr_mon();
        sw_code = 4'h6; sw_go = 1;
        @(negedge clk); sw_go = 0;
        @(negedge clk);
        halt_wr = 1; halt_val = 1;
        @(negedge clk); halt_wr = 0;
        chk(halted == 1, "R9", halted, 1);
        repeat (3) @(negedge clk);
        chk(busy_n == 0 && cal_active == 1, "R9", busy_n, 0);
        halt_wr = 1; halt_val = 0;
        @(negedge clk); halt_wr = 0;
        chk(halted == 0, "R9", halted, 0);
        wait_idle(0, "R9");
        chk(lens[0] == L_OFS + L_GAIN + 4, "R9", lens[0], L_OFS + L_GAIN + 4);

        // R9 halt while idle is ignored
        halt_wr = 1; halt_val = 1;
        @(negedge clk); halt_wr = 0;
        @(negedge clk);
        chk(halted == 0, "R9", halted, 0);

        // R5 R9 strobe ignored while halted in a system wait
        clr_mon();
        sw_code = 4'h5; sw_go = 1;
        @(negedge clk); sw_go = 0;
        halt_wr = 1; halt_val = 1;
        @(negedge clk); halt_wr = 0;
        conv_start = 1;
        @(negedge clk); conv_start = 0;
        @(negedge clk);
        chk(busy_n == 1 && cal_active == 1, "R5", busy_n, 1);
        halt_wr = 1; halt_val = 0;
        @(negedge clk); halt_wr = 0;
        wait_idle(1, "R5");
        chk(np == 1 && lens[0] == L_OFS, "R5", lens[0], L_OFS);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule